// File: doc/BRIEF.md
# Two-Level Nested Interrupt Arbiter

This block sits beside a small 8-bit CPU core. It chooses which of thirteen pending interrupt flags is served next. The sources are ten external lines, two timers and one serial port. A source takes part only when three things hold together: its flag is pending, its own enable bit is set, and the global enable is on. Each source has one priority bit that places it at the high or the low level. When several requests of the same level arrive together, a fixed interleaved polling order picks the winner. The winner's 16-bit service vector is then presented to the CPU.

The CPU side uses a request/acknowledge handshake. The block raises a request together with the vector and the winning source index, and holds all three steady until the CPU acknowledges. On acknowledge, the level of the accepted routine is marked as in service, and the accepted source index is pulsed out so that edge-type flags can be cleared. A return strobe from the CPU retires the innermost routine. Because the in-service marks are kept, nesting stays correct: a low-level routine may be interrupted only by a high-level request, and a high-level routine is never interrupted.

Arbitration runs once per machine cycle, on a one-cycle enable strobe.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, `cpu_irq_o` and `clr_valid_o` are low and no level is in service.
- R2: A source takes part in arbitration only when its `req_i` bit, its `en_i` bit and `glb_en_i` are all high. Source index encoding: 0 to 9 are external lines X0 to X9, 10 is timer T0, 11 is timer T1, 12 is serial port S0.
- R3: When requests of both levels are pending and allowed, a source whose `prio_i` bit is 1 (high level) wins over any source whose bit is 0 (low level).
- R4: Among requests of the same level, the winner is the first in this order: X0, S0, X5, T0, X6, X1, X2, X7, T1, X3, X8, X4, X9.
- R5: `vec_o` is 0x0003 + 8*k. The slot k is 0 for X0, 1 for T0, 2 for X1, 3 for T1 and 5 for S0, and n+5 for external line Xn when n is 2 to 9.
- R6: While a low-level routine is in service and no high-level routine is, only a high-level request can raise `cpu_irq_o`.
- R7: While a high-level routine is in service, no request raises `cpu_irq_o`.
- R8: Arbitration happens only in a cycle where `mc_tick_i` is high. `cpu_irq_o` rises in the next clock cycle.
- R9: While `cpu_irq_o` is high and no acknowledge has arrived, `vec_o` and `src_o` stay stable, even when requests, enables or priorities change.
- R10: `cpu_ack_i` during a raised request marks that request's level as in service. One cycle later, `cpu_irq_o` is low and `clr_valid_o` pulses for one cycle with `clr_src_o` equal to the accepted source index.
- R11: `reti_i` clears the high in-service mark if it is set, and otherwise clears the low mark.
- R12: `cpu_ack_i` while no request is raised has no effect: no clear pulse is produced, and no level is marked in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mc_tick_i | input | 1 | Machine-cycle strobe; arbitration happens only in cycles where it is high |
| req_i | input | 13 | Pending request flag of each source |
| en_i | input | 13 | Enable bit of each source |
| glb_en_i | input | 1 | Global enable |
| prio_i | input | 13 | Priority bit of each source; 1 means high level |
| cpu_irq_o | output | 1 | Request to the CPU |
| vec_o | output | 16 | Service vector of the pending request |
| src_o | output | 4 | Source index of the pending request |
| cpu_ack_i | input | 1 | CPU accepts the pending request |
| reti_i | input | 1 | CPU returns from the innermost routine |
| clr_valid_o | output | 1 | One-cycle pulse after an acknowledge |
| clr_src_o | output | 4 | Index of the source that was accepted |

## Verification
The bench builds the block with its default parameters: thirteen sources, a 4-bit index and a 16-bit vector. At this size every single source can be swept at both levels. So can every same-level pair and every mixed-level ordered pair. This checks the full polling order and the full vector map against values the bench computes by arithmetic from R4 and R5. Scripted nesting sequences then drive the in-service marks through every combination of low and high. These sequences show preemption, blocking and retirement through which requests are able to raise the CPU request.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NSRC  = 13;
    localparam int IDX_W = $clog2(NSRC);
    localparam int VEC_W = 16;
    localparam int NLVL  = 2;

    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } lvl_e;

    // Source index sitting at poll position pos (position 0 is polled first).
    function automatic logic [IDX_W-1:0] poll_src(input int pos);
        logic [IDX_W-1:0] s;
        case (pos)
            0:       s = IDX_W'(0);   // X0
            1:       s = IDX_W'(12);  // S0
            2:       s = IDX_W'(5);   // X5
            3:       s = IDX_W'(10);  // T0
            4:       s = IDX_W'(6);   // X6
            5:       s = IDX_W'(1);   // X1
            6:       s = IDX_W'(2);   // X2
            7:       s = IDX_W'(7);   // X7
            8:       s = IDX_W'(11);  // T1
            9:       s = IDX_W'(3);   // X3
            10:      s = IDX_W'(8);   // X8
            11:      s = IDX_W'(4);   // X4
            default: s = IDX_W'(9);   // X9
        endcase
        return s;
    endfunction

    // Service vector for a source index.
    function automatic logic [VEC_W-1:0] src_vector(input logic [IDX_W-1:0] idx);
        logic [VEC_W-1:0] v;
        case (idx)
            IDX_W'(0):  v = VEC_W'(16'h0003);
            IDX_W'(1):  v = VEC_W'(16'h0013);
            IDX_W'(2):  v = VEC_W'(16'h003B);
            IDX_W'(3):  v = VEC_W'(16'h0043);
            IDX_W'(4):  v = VEC_W'(16'h004B);
            IDX_W'(5):  v = VEC_W'(16'h0053);
            IDX_W'(6):  v = VEC_W'(16'h005B);
            IDX_W'(7):  v = VEC_W'(16'h0063);
            IDX_W'(8):  v = VEC_W'(16'h006B);
            IDX_W'(9):  v = VEC_W'(16'h0073);
            IDX_W'(10): v = VEC_W'(16'h000B);
            IDX_W'(11): v = VEC_W'(16'h001B);
            default:    v = VEC_W'(16'h002B);
        endcase
        return v;
    endfunction

endpackage

// File: rtl/irq_level_pick.sv
module irq_level_pick
    import irq_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int IW = IDX_W
) (
    input  logic [N-1:0]  cand_i,
    output logic          hit_o,
    output logic [IW-1:0] win_o
);

    // Walk from the last poll position to the first, so the earliest one wins.
    always_comb begin
        hit_o = 1'b0;
        win_o = '0;
        for (int pos = N - 1; pos >= 0; pos--) begin
            if (cand_i[poll_src(pos)]) begin
                hit_o = 1'b1;
                win_o = IW'(poll_src(pos));
            end
        end
    end

    always_comb begin
        if (hit_o) begin
            a_r4_winner_pending: assert (cand_i[win_o]);
        end
        a_r4_hit_iff_cand: assert (hit_o == (|cand_i));
    end

endmodule

// File: rtl/irq_inservice.sv
module irq_inservice
    import irq_pkg::*;
#(
    parameter int L = NLVL
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_i,
    input  lvl_e         set_lvl_i,
    input  logic         reti_i,
    output logic [L-1:0] ins_o
);

    typedef struct packed {
        logic [L-1:0] ins;
    } ins_st_t;

    ins_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (reti_i) begin
            if (st_q.ins[LVL_HI]) st_d.ins[LVL_HI] = 1'b0;
            else                  st_d.ins[LVL_LO] = 1'b0;
        end
        if (set_i) st_d.ins[set_lvl_i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ins_o = st_q.ins;

    a_r11_reti_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && st_q.ins[LVL_HI] && !set_i) |=> !ins_o[LVL_HI] && $stable(ins_o[LVL_LO]));
    a_r11_reti_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && !st_q.ins[LVL_HI] && !set_i) |=> ins_o == '0);
    a_r10_set_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !reti_i) |=> ins_o[$past(set_lvl_i)]);

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int IW = IDX_W,
    parameter int VW = VEC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mc_tick_i,
    input  logic [N-1:0]  req_i,
    input  logic [N-1:0]  en_i,
    input  logic          glb_en_i,
    input  logic [N-1:0]  prio_i,
    output logic          cpu_irq_o,
    output logic [VW-1:0] vec_o,
    output logic [IW-1:0] src_o,
    input  logic          cpu_ack_i,
    input  logic          reti_i,
    output logic          clr_valid_o,
    output logic [IW-1:0] clr_src_o
);

    typedef struct packed {
        logic          irq;
        logic [VW-1:0] vec;
        logic [IW-1:0] src;
        lvl_e          lvl;
        logic          clr_v;
        logic [IW-1:0] clr_src;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic [N-1:0]    elig;
    logic [N-1:0]    cand   [NLVL];
    logic [NLVL-1:0] hit;
    logic [IW-1:0]   win    [NLVL];
    logic [NLVL-1:0] ins;
    logic            allow_hi, allow_lo;
    logic            take;

    assign elig           = req_i & en_i & {N{glb_en_i}};
    assign cand[LVL_HI]   = elig & prio_i;
    assign cand[LVL_LO]   = elig & ~prio_i;

    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        irq_level_pick #(.N(N), .IW(IW)) u_pick (
            .cand_i (cand[g]),
            .hit_o  (hit[g]),
            .win_o  (win[g])
        );
    end

    assign take = st_q.irq & cpu_ack_i;

    irq_inservice #(.L(NLVL)) u_ins (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (take),
        .set_lvl_i (st_q.lvl),
        .reti_i    (reti_i),
        .ins_o     (ins)
    );

    assign allow_hi = ~ins[LVL_HI];
    assign allow_lo = ~ins[LVL_HI] & ~ins[LVL_LO];

    always_comb begin
        st_d       = st_q;
        st_d.clr_v = 1'b0;
        if (st_q.irq) begin
            if (cpu_ack_i) begin
                st_d.irq     = 1'b0;
                st_d.clr_v   = 1'b1;
                st_d.clr_src = st_q.src;
            end
        end else if (mc_tick_i) begin
            if (allow_hi && hit[LVL_HI]) begin
                st_d.irq = 1'b1;
                st_d.src = win[LVL_HI];
                st_d.vec = src_vector(win[LVL_HI]);
                st_d.lvl = LVL_HI;
            end else if (allow_lo && hit[LVL_LO]) begin
                st_d.irq = 1'b1;
                st_d.src = win[LVL_LO];
                st_d.vec = src_vector(win[LVL_LO]);
                st_d.lvl = LVL_LO;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_irq_o   = st_q.irq;
    assign vec_o       = st_q.vec;
    assign src_o       = st_q.src;
    assign clr_valid_o = st_q.clr_v;
    assign clr_src_o   = st_q.clr_src;

    a_r8_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_irq_o) |-> $past(mc_tick_i));
    a_r2_rise_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_irq_o) |-> $past(glb_en_i && (|(req_i & en_i))));
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq_o && !cpu_ack_i) |=> cpu_irq_o && $stable(vec_o) && $stable(src_o));
    a_r10_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq_o && cpu_ack_i) |=> !cpu_irq_o && clr_valid_o && clr_src_o == $past(src_o));
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid_o |=> !clr_valid_o);
    a_r12_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_irq_o && cpu_ack_i) |=> !clr_valid_o);
    a_r7_high_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_irq_o && ins[LVL_HI]) |=> !cpu_irq_o);
    a_r6_low_blocks_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_irq_o && ins[LVL_LO]) |=> (!cpu_irq_o || st_q.lvl == LVL_HI));
    a_r3_high_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_irq_o && mc_tick_i && hit[LVL_HI] && !ins[LVL_HI]) |=> st_q.lvl == LVL_HI);

endmodule

// File: tb/irq_nest_ctrl_test.sv
`timescale 1ns/1ps
module irq_nest_ctrl_test;

    localparam int N = 13;
    localparam int ORDER [N] = '{0, 12, 5, 10, 6, 1, 2, 7, 11, 3, 8, 4, 9};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mc_tick = 1'b0;
    logic [N-1:0]  req = '0;
    logic [N-1:0]  en = '1;
    logic          gen = 1'b1;
    logic [N-1:0]  prio = '0;
    logic          irq;
    logic [15:0]   vec;
    logic [3:0]    src;
    logic          ack = 1'b0;
    logic          reti = 1'b0;
    logic          clr_v;
    logic [3:0]    clr_src;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_nest_ctrl uut (
        .clk(clk), .rst_n(rst_n), .mc_tick_i(mc_tick), .req_i(req), .en_i(en),
        .glb_en_i(gen), .prio_i(prio), .cpu_irq_o(irq), .vec_o(vec), .src_o(src),
        .cpu_ack_i(ack), .reti_i(reti), .clr_valid_o(clr_v), .clr_src_o(clr_src)
    );

    function automatic int exp_vec(int idx);
        int k;
        if (idx == 0)       k = 0;
        else if (idx == 1)  k = 2;
        else if (idx <= 9)  k = idx + 5;
        else if (idx == 10) k = 1;
        else if (idx == 11) k = 3;
        else                k = 5;
        return 3 + 8 * k;
    endfunction

    function automatic int rank_of(int idx);
        for (int p = 0; p < N; p++) if (ORDER[p] == idx) return p;
        return -1;
    endfunction

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic tick1();
        mc_tick = 1'b1;
        @(negedge clk);
        mc_tick = 1'b0;
    endtask

    task automatic expect_win(int idx, string tag);
        chk(irq === 1'b1, tag, "irq raised", int'(irq), 1);
        chk(src === 4'(idx), tag, "src", int'(src), idx);
        chk(vec === 16'(exp_vec(idx)), tag, "vec", int'(vec), exp_vec(idx));
    endtask

    task automatic expect_none(string tag);
        chk(irq === 1'b0, tag, "irq idle", int'(irq), 0);
    endtask

    task automatic do_ack(int idx, string tag);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk(clr_v === 1'b1, tag, "clr pulse", int'(clr_v), 1);
        chk(clr_src === 4'(idx), tag, "clr src", int'(clr_src), idx);
        chk(irq === 1'b0, tag, "irq dropped", int'(irq), 0);
        @(negedge clk);
        chk(clr_v === 1'b0, tag, "clr one cycle", int'(clr_v), 0);
    endtask

    task automatic do_reti();
        reti = 1'b1;
        @(negedge clk);
        reti = 1'b0;
    endtask

    task automatic serve(int idx, string tag);
        expect_win(idx, tag);
        do_ack(idx, tag);
        do_reti();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(irq === 1'b0, "R1", "irq after reset", int'(irq), 0);
        chk(clr_v === 1'b0, "R1", "clr after reset", int'(clr_v), 0);
        req = 13'(1) << 4; tick1();
        serve(4, "R1");  // low level accepted => nothing was in service
        req = '0;

        // R8 no arbitration without tick
        req = 13'(1) << 5;
        repeat (3) @(negedge clk);
        expect_none("R8");
        tick1();
        serve(5, "R8");
        req = '0;

        // R2 masking
        req = 13'(1); en = ~13'(1);
        tick1(); expect_none("R2");
        en = '1; gen = 1'b0;
        tick1(); expect_none("R2");
        gen = 1'b1;
        tick1(); serve(0, "R2");
        req = '0;

        // R5 singles at both levels
        for (int lv = 0; lv < 2; lv++) begin
            for (int i = 0; i < N; i++) begin
                prio = lv ? '1 : '0;
                req = 13'(1) << i;
                tick1(); serve(i, "R5");
            end
        end
        req = '0;

        // R4 same-level pairs
        for (int lv = 0; lv < 2; lv++) begin
            prio = lv ? '1 : '0;
            for (int i = 0; i < N; i++) begin
                for (int j = i + 1; j < N; j++) begin
                    req = (13'(1) << i) | (13'(1) << j);
                    tick1();
                    serve(rank_of(i) < rank_of(j) ? i : j, "R4");
                end
            end
        end
        req = '0;

        // R3 mixed levels, high always wins
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                if (i != j) begin
                    prio = 13'(1) << i;
                    req = (13'(1) << i) | (13'(1) << j);
                    tick1(); serve(i, "R3");
                end
            end
        end
        req = '0; prio = '0;

        // R9 hold while pending
        req = 13'(1) << 9;
        tick1(); expect_win(9, "R9");
        req = (13'(1) << 9) | 13'(1); prio = 13'(1);
        tick1(); tick1();
        expect_win(9, "R9");
        req = '0; en = '0;
        tick1(); expect_win(9, "R9");
        en = '1;
        do_ack(9, "R9"); do_reti();
        prio = '0;

        // R12 stray acknowledge
        ack = 1'b1; @(negedge clk); ack = 1'b0;
        chk(clr_v === 1'b0, "R12", "no clr on stray ack", int'(clr_v), 0);
        req = 13'(1) << 3;
        tick1(); serve(3, "R12");  // low still allowed => nothing marked
        req = '0;

        // R6 / R7 / R11 nesting
        prio = 13'(1) << 10;
        req = 13'(1) << 3;
        tick1(); expect_win(3, "R6"); do_ack(3, "R6");
        req = (13'(1) << 1) | (13'(1) << 3);
        tick1(); expect_none("R6");
        req = req | (13'(1) << 10);
        tick1(); expect_win(10, "R6"); do_ack(10, "R6");
        req = '1;
        tick1(); expect_none("R7");
        tick1(); expect_none("R7");
        req = (13'(1) << 10) | (13'(1) << 1);
        do_reti();
        tick1(); expect_win(10, "R11"); do_ack(10, "R11"); do_reti();
        req = 13'(1) << 1;
        tick1(); expect_none("R11");
        do_reti();
        tick1(); serve(1, "R11");
        req = '0; prio = '0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule